// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time clock peripheral on a simple 32-bit register bus. A one-cycle strobe `tick_i`, generated elsewhere once per second, advances a free-running seconds count. Software reads the count, can preset it, and can re-zero a relative counter that measures the seconds since its last restart. A 32-bit alarm value raises an interrupt when the count steps onto it. Software can also force the interrupt on or clear it through a shared status address. The interrupt appears both as a level (the flag) and as a one-cycle pulse for edge-sensitive receivers.

The bus carries one access per cycle, marked by `req_i`. The read data and the error response come back in the following cycle and are zero in every other cycle. The block decodes a 4 KB window. Two constant identification words sit near the top of the window. Every unused offset reads as zero and answers with an error.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the seconds count, relative counter, alarm value and interrupt flag are all zero, and `rdata_o`, `err_o`, `irq_pulse_o` and `irq_level_o` are low.
- R2: Each cycle with `tick_i` high adds one to the seconds count (32-bit wrap). An access is accepted when `req_i` is high, and its `rdata_o`/`err_o` appear in the next cycle. Both are zero after a cycle without an access. A read of offset 0x000 returns the count as it stood in the access cycle.
- R3: A write to offset 0x000 leaves the count unchanged and gives `err_o`.
- R4: Offset 0x004 holds the 32-bit alarm value and reads back exactly what was last written.
- R5: A write of non-zero data to offset 0x008 sets the flag, and `irq_pulse_o` is high for the one following cycle. A write of zero clears the flag. A read of 0x008 returns the flag in bit 0 with all other bits zero. `irq_level_o` follows the flag.
- R6: A tick that moves the count onto the alarm value sets the flag and gives one pulse. The alarm fires once per such step. Presetting the count onto the alarm value does not fire it.
- R7: A read of offset 0x010 returns the count minus a base. Any write there, whatever its data, sets the base to the count it leaves, so the read is zero afterwards, even when a tick falls in the same cycle.
- R8: A write to offset 0x00C sets the count to the written value in the next cycle, and a tick in that cycle is dropped. The base moves by the same step, so the relative read keeps its value. A read of 0x00C returns zero with no error.
- R9: Only accesses with `size_i` = 2'b10 (32-bit) take effect. Any other size is ignored and gives `err_o`, with `rdata_o` zero.
- R10: Offset 0xFE0 reads 0x00041030 and offset 0xFD8 reads 0x000FFFFF. Writes to these offsets are dropped with `err_o`. Any other offset reads zero, drops writes and gives `err_o` for one cycle.
- R11: When an alarm step and a status write of zero fall in the same cycle, the alarm wins: the flag ends set and a pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| req_i | input | 1 | Access valid in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size; 2'b10 = 32-bit |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, cycle after the access |
| err_o | output | 1 | Error response, cycle after the access |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |
| irq_level_o | output | 1 | Interrupt flag |

## Verification
Two pairs of events can fall in the same cycle. An alarm step can meet a software write to the status offset. A tick can meet a preset of the count or a re-zero of the relative counter. The bench provokes each pair by placing a tick on the very cycle of the status, preset or re-zero write, with the alarm value set one second ahead where the alarm is wanted. A behavioural model, compared on every cycle, settles the outcome: the alarm wins over a clear, a preset drops the tick, and a re-zero takes the post-tick count. The wrap from 0xFFFFFFFF to zero onto an alarm of zero is also exercised.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  localparam logic [11:0] OFF_SECS  = 12'h000;
  localparam logic [11:0] OFF_MATCH = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h008;
  localparam logic [11:0] OFF_LOAD  = 12'h00C;
  localparam logic [11:0] OFF_REL   = 12'h010;
  localparam logic [11:0] OFF_MASK  = 12'hFD8;
  localparam logic [11:0] OFF_ID    = 12'hFE0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SECS,
    SEL_MATCH,
    SEL_STAT,
    SEL_LOAD,
    SEL_REL,
    SEL_ID,
    SEL_MASK
  } reg_sel_e;

  typedef struct packed {
    logic wr_match;
    logic stat_set;
    logic stat_clr;
    logic wr_load;
    logic rezero;
  } wr_cmd_t;

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_sec_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output reg_sel_e          sel_o,
  output wr_cmd_t           cmd_o,
  output logic              err_o
);

  always_comb begin
    sel_o = SEL_NONE;
    cmd_o = '0;
    err_o = 1'b0;
    if (req_i) begin
      if (size_i != SZ_WORD) begin
        err_o = 1'b1;
      end else begin
        case (addr_i)
          ADDR_W'(OFF_SECS): begin
            sel_o = SEL_SECS;
            err_o = we_i;
          end
          ADDR_W'(OFF_MATCH): begin
            sel_o          = SEL_MATCH;
            cmd_o.wr_match = we_i;
          end
          ADDR_W'(OFF_STAT): begin
            sel_o          = SEL_STAT;
            cmd_o.stat_set = we_i && (|wdata_i);
            cmd_o.stat_clr = we_i && !(|wdata_i);
          end
          ADDR_W'(OFF_LOAD): begin
            sel_o         = SEL_LOAD;
            cmd_o.wr_load = we_i;
          end
          ADDR_W'(OFF_REL): begin
            sel_o        = SEL_REL;
            cmd_o.rezero = we_i;
          end
          ADDR_W'(OFF_ID): begin
            sel_o = SEL_ID;
            err_o = we_i;
          end
          ADDR_W'(OFF_MASK): begin
            sel_o = SEL_MASK;
            err_o = we_i;
          end
          default: err_o = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              rezero_i,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] rel_o,
  output logic [DATA_W-1:0] sec_inc_o,
  output logic              adv_o
);

  logic [DATA_W-1:0] sec_q, sec_d;
  logic [DATA_W-1:0] base_q, base_d;

  // a preset drops a coincident tick
  assign adv_o     = tick_i && !load_i;
  assign sec_inc_o = sec_q + DATA_W'(1);

  always_comb begin
    if (load_i)     sec_d = load_val_i;
    else if (adv_o) sec_d = sec_inc_o;
    else            sec_d = sec_q;
  end

  always_comb begin
    if (rezero_i)    base_d = sec_d;
    else if (load_i) base_d = base_q + (load_val_i - sec_q);
    else             base_d = base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      base_q <= '0;
    end else begin
      sec_q  <= sec_d;
      base_q <= base_d;
    end
  end

  assign sec_o = sec_q;
  assign rel_o = sec_q - base_q;

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_match_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sw_set_i,
  input  logic              sw_clr_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] sec_inc_i,
  output logic [DATA_W-1:0] match_o,
  output logic              alarm_o,
  output logic              flag_o,
  output logic              pulse_o
);

  logic [DATA_W-1:0] match_q;
  logic              flag_q, pulse_q;
  logic              set_evt;

  // fires only on a step onto the value, so once per event
  assign alarm_o = adv_i && (sec_inc_i == match_q);
  assign set_evt = alarm_o || sw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_match_i) match_q <= wdata_i;
      if (set_evt)       flag_q <= 1'b1;
      else if (sw_clr_i) flag_q <= 1'b0;
      pulse_q <= set_evt;
    end
  end

  assign match_o = match_q;
  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
  import rtc_sec_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] ID_WORD   = DATA_W'(32'h0004_1030),
  parameter logic [DATA_W-1:0] MASK_WORD = DATA_W'(32'h000F_FFFF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_pulse_o,
  output logic              irq_level_o
);

  reg_sel_e          sel;
  wr_cmd_t           cmd;
  logic              dec_err;
  logic [DATA_W-1:0] sec_w, rel_w, sec_inc_w, match_w;
  logic              adv_w, alarm_w, flag_w;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  rtc_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .size_i (size_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .sel_o  (sel),
    .cmd_o  (cmd),
    .err_o  (dec_err)
  );

  rtc_sec_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (cmd.wr_load),
    .load_val_i(wdata_i),
    .rezero_i  (cmd.rezero),
    .sec_o     (sec_w),
    .rel_o     (rel_w),
    .sec_inc_o (sec_inc_w),
    .adv_o     (adv_w)
  );

  rtc_alarm_irq #(.DATA_W(DATA_W)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_match_i(cmd.wr_match),
    .wdata_i   (wdata_i),
    .sw_set_i  (cmd.stat_set),
    .sw_clr_i  (cmd.stat_clr),
    .adv_i     (adv_w),
    .sec_inc_i (sec_inc_w),
    .match_o   (match_w),
    .alarm_o   (alarm_w),
    .flag_o    (flag_w),
    .pulse_o   (irq_pulse_o)
  );

  always_comb begin
    case (sel)
      SEL_SECS:  rd_mux = sec_w;
      SEL_MATCH: rd_mux = match_w;
      SEL_STAT:  rd_mux = DATA_W'(flag_w);
      SEL_REL:   rd_mux = rel_w;
      SEL_ID:    rd_mux = ID_WORD;
      SEL_MASK:  rd_mux = MASK_WORD;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (req_i && !we_i && !dec_err) ? rd_mux : '0;
      err_q   <= dec_err;
    end
  end

  assign rdata_o     = rdata_q;
  assign err_o       = err_q;
  assign irq_level_o = flag_w;

endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              irq_pulse_o,
  input logic              irq_level_o,
  input logic [DATA_W-1:0] sec_w,
  input logic [DATA_W-1:0] rel_w,
  input logic [DATA_W-1:0] match_w,
  input logic              alarm_w,
  input logic              stat_clr
);

  logic word_wr;
  assign word_wr = req_i && we_i && (size_i == 2'b10);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && rdata_o == '0)); // R2

  AST_DATA_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && addr_i == ADDR_W'(12'h000)) |=> err_o); // R3

  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_wr && addr_i == ADDR_W'(12'h004)) |=> $stable(match_w)); // R4

  AST_LEVEL_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_level_o); // R5

  AST_ALARM_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_w |=> (irq_pulse_o && irq_level_o)); // R6

  AST_REL_REZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && addr_i == ADDR_W'(12'h010)) |=> (rel_w == '0)); // R7

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && addr_i == ADDR_W'(12'h00C)) |=> (sec_w == $past(wdata_i))); // R8

  AST_BAD_SIZE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'b10) |=> (err_o && rdata_o == '0)); // R9

  AST_ALARM_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_w && stat_clr) |=> irq_level_o); // R11

endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .size_i     (size_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .err_o      (err_o),
  .irq_pulse_o(irq_pulse_o),
  .irq_level_o(irq_level_o),
  .sec_w      (sec_w),
  .rel_w      (rel_w),
  .match_w    (match_w),
  .alarm_w    (alarm_w),
  .stat_clr   (cmd.stat_clr)
);

// File: tb/test_rtc_seconds_alarm.sv
`timescale 1ns/1ps
module test_rtc_seconds_alarm;

  localparam logic [11:0] A_SECS = 12'h000, A_MATCH = 12'h004, A_STAT = 12'h008,
                          A_LOAD = 12'h00C, A_REL = 12'h010, A_MASK = 12'hFD8,
                          A_ID = 12'hFE0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = 2'b10;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, irq_pulse_o, irq_level_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_sec = '0, m_base = '0, m_match = '0;
  logic        m_flag = 0, m_pulse = 0, m_err = 0;
  logic [31:0] m_rdata = '0;

  always #4 clk = ~clk;

  rtc_seconds_alarm i_rtc_seconds_alarm (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .err_o(err_o), .irq_pulse_o(irq_pulse_o), .irq_level_o(irq_level_o)
  );

  task automatic expect_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(logic rq, logic w, logic [11:0] a, logic [1:0] sz,
                       logic [31:0] d, logic tk);
    logic ld, rz, sset, sclr, alarm;
    logic [31:0] nsec, nbase;
    ld = 0; rz = 0; sset = 0; sclr = 0;
    m_rdata = '0; m_err = 0;
    if (rq) begin
      if (sz != 2'b10) m_err = 1;
      else if (!w) begin
        case (a)
          A_SECS:  m_rdata = m_sec;
          A_MATCH: m_rdata = m_match;
          A_STAT:  m_rdata = {31'd0, m_flag};
          A_LOAD:  m_rdata = '0;
          A_REL:   m_rdata = m_sec - m_base;
          A_ID:    m_rdata = 32'h0004_1030;
          A_MASK:  m_rdata = 32'h000F_FFFF;
          default: m_err = 1;
        endcase
      end else begin
        case (a)
          A_MATCH: m_match = d;
          A_STAT:  if (d != 0) sset = 1; else sclr = 1;
          A_LOAD:  ld = 1;
          A_REL:   rz = 1;
          default: m_err = 1;
        endcase
      end
    end
    alarm = tk && !ld && ((m_sec + 32'd1) == m_match);
    nsec  = ld ? d : (tk ? m_sec + 32'd1 : m_sec);
    nbase = rz ? nsec : (ld ? m_base + (d - m_sec) : m_base);
    m_sec = nsec;
    m_base = nbase;
    m_pulse = alarm || sset;
    if (alarm || sset) m_flag = 1;
    else if (sclr) m_flag = 0;
  endtask

  task automatic compare(string tag);
    expect_val(tag, "rdata", rdata_o, m_rdata);
    expect_val(tag, "err", {31'd0, err_o}, {31'd0, m_err});
    expect_val(tag, "pulse", {31'd0, irq_pulse_o}, {31'd0, m_pulse});
    expect_val(tag, "level", {31'd0, irq_level_o}, {31'd0, m_flag});
  endtask

  task automatic cyc(string tag, logic rq, logic w, logic [11:0] a, logic [1:0] sz,
                     logic [31:0] d, logic tk);
    req_i = rq; we_i = w; addr_i = a; size_i = sz; wdata_i = d; tick_i = tk;
    model(rq, w, a, sz, d, tk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n, logic tk);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 12'h0, 2'b10, 32'h0, tk);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    cyc(tag, 1, 0, a, 2'b10, 32'h0, 0);
  endtask

  task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
    cyc(tag, 1, 1, a, 2'b10, d, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
    rd("R1", A_SECS); rd("R1", A_REL); rd("R1", A_MATCH); rd("R1", A_STAT);
    idle("R1", 1, 0);

    // R2: counting and read timing
    idle("R2", 5, 1);
    rd("R2", A_SECS);
    cyc("R2", 1, 0, A_SECS, 2'b10, 0, 1);
    rd("R2", A_SECS);
    idle("R2", 1, 0);

    // R3: data offset is read-only
    wr("R3", A_SECS, 32'h1234_5678);
    rd("R3", A_SECS);

    // R4: alarm value read back
    wr("R4", A_MATCH, 32'hDEAD_BEEF);
    rd("R4", A_MATCH);
    wr("R4", A_MATCH, 32'h8000_0001);
    rd("R4", A_MATCH);

    // R5: software set and clear
    wr("R5", A_STAT, 32'h0000_0100);
    rd("R5", A_STAT);
    wr("R5", A_STAT, 32'h0);
    rd("R5", A_STAT);
    idle("R5", 1, 0);

    // R6: alarm on tick, once per event
    wr("R6", A_MATCH, m_sec + 32'd3);
    idle("R6", 6, 1);
    rd("R6", A_STAT);
    wr("R6", A_STAT, 32'h0);
    idle("R6", 3, 1);
    wr("R6", A_MATCH, 32'd500);
    wr("R6", A_LOAD, 32'd500);
    idle("R6", 2, 1);
    rd("R6", A_STAT);

    // R7: relative counter
    idle("R7", 4, 1);
    rd("R7", A_REL);
    cyc("R7", 1, 1, A_REL, 2'b10, 32'hFFFF_FFFF, 1);
    rd("R7", A_REL);
    idle("R7", 3, 1);
    rd("R7", A_REL);

    // R8: preset keeps relative value, drops coincident tick
    cyc("R8", 1, 1, A_LOAD, 2'b10, 32'd100, 1);
    rd("R8", A_SECS);
    rd("R8", A_REL);
    rd("R8", A_LOAD);
    wr("R8", A_LOAD, 32'd7);
    rd("R8", A_REL);

    // R9: bad sizes
    cyc("R9", 1, 1, A_MATCH, 2'b01, 32'h5555_5555, 0);
    cyc("R9", 1, 1, A_STAT, 2'b00, 32'h1, 0);
    cyc("R9", 1, 0, A_SECS, 2'b11, 32'h0, 0);
    rd("R9", A_MATCH);
    rd("R9", A_STAT);

    // R10: id words and undefined offsets
    rd("R10", A_ID);
    rd("R10", A_MASK);
    wr("R10", A_ID, 32'h0);
    rd("R10", A_ID);
    rd("R10", 12'h020);
    wr("R10", 12'h013, 32'hFFFF_FFFF);
    rd("R10", 12'h006);
    idle("R10", 1, 0);

    // R11: alarm against same-cycle clear, and against same-cycle set
    wr("R11", A_STAT, 32'h1);
    wr("R11", A_MATCH, m_sec + 32'd1);
    cyc("R11", 1, 1, A_STAT, 2'b10, 32'h0, 1);
    rd("R11", A_STAT);
    wr("R11", A_STAT, 32'h0);
    wr("R11", A_MATCH, m_sec + 32'd1);
    cyc("R11", 1, 1, A_STAT, 2'b10, 32'h2, 1);
    idle("R11", 2, 0);

    // R6 at wrap: count 0xFFFFFFFF steps onto alarm 0
    wr("R6", A_STAT, 32'h0);
    wr("R6", A_MATCH, 32'h0);
    wr("R6", A_LOAD, 32'hFFFF_FFFF);
    idle("R6", 1, 1);
    rd("R6", A_SECS);
    rd("R6", A_STAT);
    idle("R6", 2, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule